// File: doc/BRIEF.md
# Dual-Mode SPI Receive Controller

This block is the receive half of an SPI master. It drives the serial clock and chip select, samples the serial input most-significant bit first on each rising clock edge (mode 0), and assembles bytes in a shift register. Software starts a transfer of a programmed number of bytes by writing the control port with the enable bit set. It polls a transfer-end flag to learn when the transfer is complete.

A mode bit picks where finished bytes go. In single-unit mode each byte lands in one data register, and the receive interrupt follows that register's valid state. In sequential mode bytes enter a 32-byte FIFO, and the interrupt is raised once the fill level reaches a chosen threshold of half or all of the FIFO. Bytes that find no room are dropped, and a sticky overrun flag records the loss. Control writes made while a transfer runs are discarded whole, so the mode cannot change in the middle of a reception.

Top module: `spi_rx_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, rx_irq is 0 and the status word reads 0x0100. Status layout: bits [7:0] FIFO level, bit 8 empty, bit 9 overrun, bit 10 transfer end, other bits 0.
- R2: A control write with ctl_en=1 while idle starts a transfer of ctl_nbytes+1 bytes. cs_n is low for the whole transfer and sclk idles low. miso is sampled on each sclk rising edge, and the first bit sampled becomes bit 7 of the byte.
- R3: In single-unit mode (mode bit 0), a finished byte is stored in the data register and rx_irq goes to 1. A data read (rd_en=1, rd_sel=0) returns the byte in rd_data[7:0] and drops rx_irq to 0.
- R4: In single-unit mode, a byte that finishes while the data register is still unread is discarded and the overrun flag is set. The flag stays set until a pulse on ovr_clr.
- R5: In sequential mode (mode bit 1), bytes are pushed into the FIFO and data reads return them in arrival order. The level field counts the stored bytes from 0 to 32, and each data read removes one byte.
- R6: In sequential mode, rx_irq is 1 exactly when the level is at least the threshold. The threshold is 16 when the threshold bit is 0 and 32 when it is 1.
- R7: A byte that finishes while the FIFO holds 32 bytes is discarded and the overrun flag is set. The level stays at 32.
- R8: A control write made while a transfer is in progress has no effect, and the mode, threshold and byte count in use are left unchanged.
- R9: The transfer-end flag is cleared when a transfer starts. It is set when the last sclk falling edge of the transfer ends the transfer and cs_n returns high.
- R10: If a data read and the completion of a byte fall in the same clock cycle, the read returns the previously held byte and the new byte is kept, with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Start a transfer with this write |
| ctl_seq | input | 1 | Mode: 0 single-unit, 1 sequential FIFO |
| ctl_thr32 | input | 1 | FIFO interrupt threshold: 0 for 16, 1 for 32 |
| ctl_nbytes | input | NW | Number of bytes in the transfer, minus one |
| rd_en | input | 1 | Read strobe; pops data when rd_sel is 0 |
| rd_sel | input | 1 | Read select: 0 data, 1 status |
| ovr_clr | input | 1 | Status write that clears the overrun flag |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Generated serial clock |
| cs_n | output | 1 | Chip select, low during a transfer |
| rx_irq | output | 1 | Receive-full interrupt |
| rd_data | output | 16 | Read data: byte or status word |

## Verification
A data read that pops the storage can land in the same clock edge as a byte completing. In single-unit mode a wrong ordering shows up either as a false overrun or as a lost byte. The bench counts sclk rising edges during the second byte and raises the data read so that it coincides with the edge of the eighth rising edge. It then expects the old byte on that read, the new byte on the next read, and the overrun flag still clear. Reads at a full FIFO rely on the same rule: a pop frees a slot in the same cycle that a push uses it.

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl #(
  parameter int DIV   = 4,
  parameter int DEPTH = 32,
  parameter int NW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_en,
  input  logic          ctl_seq,
  input  logic          ctl_thr32,
  input  logic [NW-1:0] ctl_nbytes,
  input  logic          rd_en,
  input  logic          rd_sel,
  input  logic          ovr_clr,
  input  logic          miso,
  output logic          sclk,
  output logic          cs_n,
  output logic          rx_irq,
  output logic [15:0]   rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          busy, stop_q, mode_q, thr_q, uvalid, ovr, tend;
  logic [CW-1:0] cnt;
  logic [2:0]    bitc;
  logic [NW-1:0] rem;
  logic [6:0]    sh;
  logic [7:0]    udata;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl;

  wire tick  = busy && (cnt == CW'(DIV - 1));
  wire rise  = tick && !sclk;
  wire fall  = tick && sclk;
  wire done  = rise && (bitc == 3'd7);
  wire [7:0] nb = {sh, miso};
  wire pop   = rd_en && !rd_sel;
  wire full  = (lvl == LW'(DEPTH));
  wire fpop  = pop && mode_q && (lvl != '0);
  wire fpush = done && mode_q && (!full || fpop);
  wire start = ctl_we && !busy && ctl_en;
  wire cfg   = ctl_we && !busy;

  assign cs_n   = !busy;
  assign rx_irq = mode_q ? (lvl >= (thr_q ? LW'(DEPTH) : LW'(DEPTH / 2))) : uvalid;

  wire empty = mode_q ? (lvl == '0) : !uvalid;
  wire [7:0] dbyte = mode_q ? ((lvl != '0) ? mem[rp] : 8'h00) : udata;
  assign rd_data = rd_sel ? {5'b0, tend, ovr, empty, {(8 - LW){1'b0}}, lvl}
                          : {8'h00, dbyte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stop_q <= 1'b0; mode_q <= 1'b0; thr_q <= 1'b0;
      cnt <= '0; bitc <= '0; rem <= '0; sh <= '0; sclk <= 1'b0; tend <= 1'b0;
    end else begin
      if (cfg) begin
        mode_q <= ctl_seq;
        thr_q  <= ctl_thr32;
      end
      if (start) begin
        busy <= 1'b1; stop_q <= 1'b0; tend <= 1'b0;
        cnt <= '0; bitc <= '0; rem <= ctl_nbytes; sclk <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (tick) sclk <= !sclk;
        if (rise) begin
          sh   <= nb[6:0];
          bitc <= bitc + 3'd1;
        end
        if (done) begin
          if (rem == '0) stop_q <= 1'b1;
          else rem <= rem - NW'(1);
        end
        if (fall && stop_q) begin
          busy <= 1'b0;
          tend <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uvalid <= 1'b0; udata <= '0; ovr <= 1'b0;
      wp <= '0; rp <= '0; lvl <= '0;
    end else begin
      if (ovr_clr) ovr <= 1'b0;
      if (pop && !mode_q) uvalid <= 1'b0;
      if (done && !mode_q) begin
        if (uvalid && !pop) ovr <= 1'b1;
        else begin
          udata  <= nb;
          uvalid <= 1'b1;
        end
      end
      if (done && mode_q && !fpush) ovr <= 1'b1;
      if (fpush) wp <= wp + AW'(1);
      if (fpop)  rp <= rp + AW'(1);
      if (fpush && !fpop) lvl <= lvl + LW'(1);
      else if (fpop && !fpush) lvl <= lvl - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fpush) mem[wp] <= nb;
  end

  p_level_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));
  p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == $past(lvl)) || (lvl == $past(lvl) + LW'(1)) || (lvl == $past(lvl) - LW'(1)));
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
  p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_tend_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> (cs_n && $past(!cs_n)));
endmodule

// File: tb/spi_rx_ctrl_tb_top.sv
module spi_rx_ctrl_tb_top;
  localparam int DIV = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_en = 0, ctl_seq = 0, ctl_thr32 = 0;
  logic [5:0] ctl_nbytes = '0;
  logic rd_en = 0, rd_sel = 0, ovr_clr = 0, miso = 0;
  logic sclk, cs_n, rx_irq;
  logic [15:0] rd_data;
  int errors = 0, checks = 0;
  logic [7:0] slv_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] cur = '0;
  int bi = 0;
  bit idle = 1'b1;
  logic [15:0] st;

  always #5 clk = ~clk;

  spi_rx_ctrl #(.DIV(DIV), .DEPTH(32), .NW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_seq(ctl_seq),
    .ctl_thr32(ctl_thr32), .ctl_nbytes(ctl_nbytes), .rd_en(rd_en), .rd_sel(rd_sel),
    .ovr_clr(ovr_clr), .miso(miso), .sclk(sclk), .cs_n(cs_n), .rx_irq(rx_irq),
    .rd_data(rd_data));

  always @(negedge sclk or negedge cs_n or posedge cs_n) begin
    if (cs_n) idle = 1'b1;
    else if (idle) begin
      idle = 1'b0; bi = 0;
      cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
      miso = cur[7];
    end else begin
      bi++;
      if (bi == 8) begin
        bi = 0;
        cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
      end
      miso = cur[7 - bi];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit keep);
    slv_q.push_back(b);
    if (keep) exp_q.push_back(b);
  endtask

  task automatic ctl(input bit en, input bit seq, input bit thr, input int n);
    @(negedge clk);
    ctl_we = 1; ctl_en = en; ctl_seq = seq; ctl_thr32 = thr; ctl_nbytes = 6'(n);
    @(negedge clk);
    ctl_we = 0; ctl_en = 0;
  endtask

  task automatic rd_status();
    @(negedge clk);
    rd_sel = 1; #1 st = rd_data;
  endtask

  task automatic wait_tend();
    do rd_status(); while (!st[10]);
  endtask

  task automatic rd_pop(input string tag);
    logic [7:0] e;
    @(negedge clk);
    rd_sel = 0; rd_en = 1; #1;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
    chk(rd_data[7:0] === e, tag, rd_data[7:0], e);
    @(posedge clk); #1 rd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_status();
    chk(st == 16'h0100, "R1 status", st, 16'h0100);
    chk({cs_n, sclk, rx_irq} == 3'b100, "R1 pins", {cs_n, sclk, rx_irq}, 3'b100);

    send(8'hA5, 1);
    ctl(1, 0, 0, 0);
    rd_status();
    chk(st[10] == 0 && cs_n == 0, "R9 tend cleared on start", st[10], 0);
    wait_tend();
    chk(rx_irq == 1, "R3 irq unit", rx_irq, 1);
    chk(cs_n == 1, "R9 cs high at end", cs_n, 1);
    rd_pop("R2 R3 unit byte msb-first");
    #2 chk(rx_irq == 0, "R3 irq drops after read", rx_irq, 0);

    send(8'h3C, 1); send(8'hC3, 0);
    ctl(1, 0, 0, 1);
    wait_tend();
    chk(st[9] == 1, "R4 overrun set", st[9], 1);
    rd_pop("R4 first byte kept");
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    rd_status();
    chk(st[9] == 0, "R4 overrun cleared", st[9], 0);

    send(8'h69, 1);
    ctl(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    ctl(0, 1, 1, 5);
    wait_tend();
    chk(rx_irq == 1 && st[7:0] == 0, "R8 mode write ignored while busy", {rx_irq, st[7:0]}, 9'h100);
    rd_pop("R8 byte in unit register");

    ctl(0, 1, 0, 0);
    for (int i = 0; i < 15; i++) send(8'(i * 7 + 1), 1);
    ctl(1, 1, 0, 14);
    wait_tend();
    chk(rx_irq == 0 && st[7:0] == 15, "R6 below 16", {rx_irq, st[7:0]}, 15);
    send(8'hEE, 1);
    ctl(1, 1, 0, 0);
    wait_tend();
    chk(rx_irq == 1 && st[7:0] == 16, "R6 at 16", {rx_irq, st[7:0]}, 9'h110);
    rd_pop("R5 fifo order first");
    #2 chk(rx_irq == 0, "R6 irq drops below 16", rx_irq, 0);
    for (int i = 1; i < 16; i++) rd_pop("R5 fifo order");
    rd_status();
    chk(st[8] == 1 && st[7:0] == 0, "R5 empty", st, 16'h0500);

    ctl(0, 1, 1, 0);
    for (int i = 0; i < 31; i++) send(8'(8'hF0 - i * 3), 1);
    ctl(1, 1, 1, 30);
    wait_tend();
    chk(rx_irq == 0 && st[7:0] == 31, "R6 thr32 below", {rx_irq, st[7:0]}, 31);
    send(8'h5A, 1); send(8'h11, 0); send(8'h22, 0);
    ctl(1, 1, 1, 2);
    wait_tend();
    chk(rx_irq == 1 && st[7:0] == 32, "R6 thr32 at 32", {rx_irq, st[7:0]}, 9'h120);
    chk(st[9] == 1, "R7 overrun on full", st[9], 1);
    for (int i = 0; i < 32; i++) rd_pop("R7 R5 full fifo contents");
    rd_status();
    chk(st[7:0] == 0, "R7 discarded bytes absent", st[7:0], 0);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;

    ctl(0, 0, 0, 0);
    send(8'h81, 1);
    ctl(1, 0, 0, 0);
    wait_tend();
    send(8'h7E, 1);
    ctl(1, 0, 0, 0);
    repeat (7) @(posedge sclk);
    repeat (2 * DIV - 1) @(posedge clk);
    @(negedge clk);
    rd_sel = 0; rd_en = 1; #1;
    e = exp_q.pop_front();
    chk(rd_data[7:0] == e, "R10 same-cycle read old byte", rd_data[7:0], e);
    @(posedge clk); #1 rd_en = 0;
    wait_tend();
    chk(st[9] == 0, "R10 no overrun", st[9], 0);
    rd_pop("R10 new byte kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule